// File: doc/BRIEF.md
# I2C Address-Phase Retry Sequencer

This block drives the address phase of an I2C transaction on behalf of a byte-level I2C master. Slow targets such as serial EEPROMs can refuse their address with a NACK while an internal write cycle is still running. A start request therefore begins a loop. The block first clears any bus error the master still holds and forces the master's bus state to idle. It then waits for the bus to become free, has the master send the address byte, and acts on the response that comes back.

A NACK on a write-direction address sends the block back to wait for the bus, and it tries again. This continues until a millisecond timeout, measured from the system clock, has run out. A NACK on a read-direction address fails at once. An arbitration loss or a bus fault ends the sequence immediately and also clears the master's transfer count. Every failure sets a sticky error bit and asks the master for a STOP. An ACK ends the sequence successfully without a STOP. Each sequence ends with a one-cycle done strobe, which reports whether the sequence succeeded.

Top module: `i2c_start_retry`

## Requirements
- R1: After reset, busy, done, success, addr_issue, stop_issue, clr_bus_err, force_idle and xfer_cnt_clr are low and err_flags is zero.
- R2: A start_req seen while busy is low is accepted, and busy goes high in the next cycle. dev_addr and rd_dir are captured at that edge. A start_req seen while busy is high is ignored.
- R3: In the first cycle after acceptance (the preparation cycle), clr_bus_err and force_idle are both high if bus_err_pending is high, and both low otherwise. They are low in every other cycle.
- R4: addr_issue is a one-cycle strobe. It occurs only in the cycle after one in which bus_busy was low while the block was waiting for the bus. While bus_busy stays high, no address is issued.
- R5: While addr_issue is high, addr_byte holds the captured 7-bit address in bits 7:1, with bit 0 = 1 for a read and 0 for a write.
- R6: A response (addr_done high while the block waits for a response) with arb_lost high sets err_flags bit 0. A response with bus_fault high sets err_flags bit 1. In either case stop_issue and xfer_cnt_clr are high in that cycle and no retry follows.
- R7: Elapsed time is floor(n / CYCLES_PER_MS), where n = 0 in the cycle after the preparation cycle and n rises by one each cycle. A write-direction NACK with elapsed time ≤ TIMEOUT_MS produces no STOP, and the block returns to waiting for the bus and issues the address again.
- R8: A write-direction NACK with elapsed time > TIMEOUT_MS sets err_flags bit 2 and raises stop_issue in that cycle.
- R9: A read-direction NACK (addr_ack low) sets err_flags bit 3 and raises stop_issue in that cycle.
- R10: An ACK without a fault ends the sequence with success high and stop_issue low.
- R11: done is a one-cycle pulse in the cycle after the deciding response. success and the updated err_flags are valid with it, and busy falls in the next cycle.
- R12: err_flags bits stay set until err_clr is high. err_clr zeroes them at the next edge, except for bits being set at that same edge, which end up set.
- R13: addr_done and its qualifiers have no effect unless the block is waiting for a response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_req | input | 1 | Request to run an address sequence |
| rd_dir | input | 1 | Direction of the request, 1 = read |
| dev_addr | input | 7 | 7-bit target address |
| err_clr | input | 1 | Clears the sticky error bits |
| bus_busy | input | 1 | Master reports another owner holds the bus |
| bus_err_pending | input | 1 | Master still holds an earlier bus error |
| addr_done | input | 1 | Master finished the address byte |
| addr_ack | input | 1 | Target acknowledged (valid with addr_done) |
| arb_lost | input | 1 | Arbitration was lost (valid with addr_done) |
| bus_fault | input | 1 | Bus error was detected (valid with addr_done) |
| clr_bus_err | output | 1 | Clear the master's pending bus error |
| force_idle | output | 1 | Force the master's bus state to idle |
| addr_issue | output | 1 | Send addr_byte with a START |
| addr_byte | output | 8 | Address byte with the direction bit |
| stop_issue | output | 1 | Ask the master for a STOP |
| xfer_cnt_clr | output | 1 | Reset the master's pending transfer count |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle end-of-sequence strobe |
| success | output | 1 | Sequence ended with an ACK (valid with done) |
| err_flags | output | 4 | Sticky errors: 0 arbitration, 1 bus, 2 timeout, 3 read NACK |

## Verification
The assertions check, on every cycle, the rules that are local in time. Addresses go out only after a free-bus cycle, and the strobes last one cycle. busy falls right after done, and an ACK never causes a STOP. Responses outside the wait state are inert. Sticky bits never drop without err_clr, and the elapsed-time counter never decreases. Only the bench scenarios can show the retry-versus-timeout decision at the exact millisecond boundary, the address byte coding, the error bit chosen for each outcome, and the interplay of clear and set across whole sequences.

// File: rtl/i2c_sr_pkg.sv
package i2c_sr_pkg;
  localparam int ADDR_BITS = 7;
  localparam int ERR_BITS  = 4;
  localparam int MS_W      = 16;

  localparam int E_ARB = 0;
  localparam int E_BUS = 1;
  localparam int E_TMO = 2;
  localparam int E_NAK = 3;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PREP,
    S_WAIT_BUS,
    S_ISSUE,
    S_WAIT_RESP,
    S_DONE
  } seq_state_t;

  // address byte: target address above, direction in bit 0 (1 = read)
  function automatic logic [7:0] form_addr_byte(input logic [ADDR_BITS-1:0] a, input logic rd);
    return {a, rd};
  endfunction

  // the window counts as exhausted only once strictly past the limit
  function automatic logic window_exceeded(input logic [MS_W-1:0] elapsed, input logic [MS_W-1:0] limit);
    return elapsed > limit;
  endfunction
endpackage

// File: rtl/i2c_sr_ms_timer.sv
module i2c_sr_ms_timer
  import i2c_sr_pkg::*;
#(
  parameter int CYCLES_PER_MS = 50000,
  parameter int TIMEOUT_MS    = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic expired
);
  localparam int PRE_W = (CYCLES_PER_MS > 1) ? $clog2(CYCLES_PER_MS) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CYCLES_PER_MS - 1);
  localparam logic [MS_W-1:0]  LIMIT    = MS_W'(TIMEOUT_MS);

  logic [PRE_W-1:0] pre_q;
  logic [MS_W-1:0]  ms_q;
  logic             ms_tick;
  logic             ms_sat;

  assign ms_tick = (pre_q == PRE_LAST);
  assign ms_sat  = &ms_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      ms_q  <= '0;
    end else if (restart) begin
      pre_q <= '0;
      ms_q  <= '0;
    end else begin
      pre_q <= ms_tick ? '0 : pre_q + 1'b1;
      if (ms_tick && !ms_sat) ms_q <= ms_q + 1'b1;
    end
  end

  assign expired = window_exceeded(ms_q, LIMIT);

  AST_MS_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |=> (ms_q >= $past(ms_q))); // R7
  AST_MS_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !ms_tick) |=> $stable(ms_q)); // R7
endmodule

// File: rtl/i2c_sr_err_bank.sv
module i2c_sr_err_bank
  import i2c_sr_pkg::*;
#(
  parameter int NBITS = ERR_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [NBITS-1:0] set_vec,
  output logic [NBITS-1:0] flags
);
  logic [NBITS-1:0] flags_q;

  for (genvar g = 0; g < NBITS; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flags_q[g] <= 1'b0;
      else if (set_vec[g]) flags_q[g] <= 1'b1;
      else if (clr)        flags_q[g] <= 1'b0;
    end
  end

  assign flags = flags_q;

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((flags_q & $past(flags_q)) == $past(flags_q))); // R12
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((flags_q & $past(set_vec)) == $past(set_vec))); // R12
endmodule

// File: rtl/i2c_sr_ctrl.sv
module i2c_sr_ctrl
  import i2c_sr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_req,
  input  logic                 rd_dir,
  input  logic [ADDR_BITS-1:0] dev_addr,
  input  logic                 bus_busy,
  input  logic                 bus_err_pending,
  input  logic                 addr_done,
  input  logic                 addr_ack,
  input  logic                 arb_lost,
  input  logic                 bus_fault,
  input  logic                 window_over,
  output logic                 timer_restart,
  output logic [ERR_BITS-1:0]  err_set,
  output logic                 clr_bus_err,
  output logic                 force_idle,
  output logic                 addr_issue,
  output logic [7:0]           addr_byte,
  output logic                 stop_issue,
  output logic                 xfer_cnt_clr,
  output logic                 busy,
  output logic                 done,
  output logic                 success
);
  seq_state_t            state_q, state_d;
  logic [ADDR_BITS-1:0]  addr_q;
  logic                  rd_q;
  logic                  ok_q;

  // named events for the checks below
  logic accept_evt, resp_evt, fault_evt, ack_evt, nack_evt;
  logic rd_nack_evt, tmo_evt, retry_evt, fail_evt;

  assign accept_evt  = (state_q == S_IDLE) && start_req;
  assign resp_evt    = (state_q == S_WAIT_RESP) && addr_done;
  assign fault_evt   = resp_evt && (arb_lost || bus_fault);
  assign ack_evt     = resp_evt && !fault_evt && addr_ack;
  assign nack_evt    = resp_evt && !fault_evt && !addr_ack;
  assign rd_nack_evt = nack_evt && rd_q;
  assign tmo_evt     = nack_evt && !rd_q && window_over;
  assign retry_evt   = nack_evt && !rd_q && !window_over;
  assign fail_evt    = fault_evt || rd_nack_evt || tmo_evt;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:      if (start_req) state_d = S_PREP;
      S_PREP:      state_d = S_WAIT_BUS;
      S_WAIT_BUS:  if (!bus_busy) state_d = S_ISSUE;
      S_ISSUE:     state_d = S_WAIT_RESP;
      S_WAIT_RESP: begin
        if (retry_evt)                 state_d = S_WAIT_BUS;
        else if (ack_evt || fail_evt)  state_d = S_DONE;
      end
      S_DONE:      state_d = S_IDLE;
      default:     state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      addr_q  <= '0;
      rd_q    <= 1'b0;
      ok_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept_evt) begin
        addr_q <= dev_addr;
        rd_q   <= rd_dir;
        ok_q   <= 1'b0;
      end
      if (resp_evt) ok_q <= ack_evt;
    end
  end

  assign timer_restart = (state_q == S_PREP);
  assign clr_bus_err   = (state_q == S_PREP) && bus_err_pending;
  assign force_idle    = (state_q == S_PREP) && bus_err_pending;
  assign addr_issue    = (state_q == S_ISSUE);
  assign addr_byte     = form_addr_byte(addr_q, rd_q);
  assign stop_issue    = fail_evt;
  assign xfer_cnt_clr  = fault_evt;
  assign busy          = (state_q != S_IDLE);
  assign done          = (state_q == S_DONE);
  assign success       = done && ok_q;

  always_comb begin
    err_set        = '0;
    err_set[E_ARB] = fault_evt && arb_lost;
    err_set[E_BUS] = fault_evt && bus_fault;
    err_set[E_TMO] = tmo_evt;
    err_set[E_NAK] = rd_nack_evt;
  end

  AST_ISSUE_NEEDS_FREE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    addr_issue |-> $past(!bus_busy)); // R4
  AST_ISSUE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    addr_issue |=> !addr_issue); // R4
  AST_PREP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    clr_bus_err |=> !clr_bus_err); // R3
  AST_ACK_NO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    ack_evt |-> !stop_issue); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_BUSY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R11
  AST_STRAY_RESP_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_done && (state_q != S_WAIT_RESP)) |-> (!stop_issue && !xfer_cnt_clr)); // R13
  AST_RETRY_REWAITS: assert property (@(posedge clk) disable iff (!rst_n)
    retry_evt |=> (busy && !done && !addr_issue)); // R7
endmodule

// File: rtl/i2c_start_retry.sv
module i2c_start_retry
  import i2c_sr_pkg::*;
#(
  parameter int CYCLES_PER_MS = 50000,
  parameter int TIMEOUT_MS    = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_req,
  input  logic                 rd_dir,
  input  logic [ADDR_BITS-1:0] dev_addr,
  input  logic                 err_clr,
  input  logic                 bus_busy,
  input  logic                 bus_err_pending,
  input  logic                 addr_done,
  input  logic                 addr_ack,
  input  logic                 arb_lost,
  input  logic                 bus_fault,
  output logic                 clr_bus_err,
  output logic                 force_idle,
  output logic                 addr_issue,
  output logic [7:0]           addr_byte,
  output logic                 stop_issue,
  output logic                 xfer_cnt_clr,
  output logic                 busy,
  output logic                 done,
  output logic                 success,
  output logic [ERR_BITS-1:0]  err_flags
);
  logic                timer_restart;
  logic                window_over;
  logic [ERR_BITS-1:0] err_set;

  i2c_sr_ms_timer #(
    .CYCLES_PER_MS(CYCLES_PER_MS),
    .TIMEOUT_MS   (TIMEOUT_MS)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(timer_restart),
    .expired(window_over)
  );

  i2c_sr_ctrl u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_req      (start_req),
    .rd_dir         (rd_dir),
    .dev_addr       (dev_addr),
    .bus_busy       (bus_busy),
    .bus_err_pending(bus_err_pending),
    .addr_done      (addr_done),
    .addr_ack       (addr_ack),
    .arb_lost       (arb_lost),
    .bus_fault      (bus_fault),
    .window_over    (window_over),
    .timer_restart  (timer_restart),
    .err_set        (err_set),
    .clr_bus_err    (clr_bus_err),
    .force_idle     (force_idle),
    .addr_issue     (addr_issue),
    .addr_byte      (addr_byte),
    .stop_issue     (stop_issue),
    .xfer_cnt_clr   (xfer_cnt_clr),
    .busy           (busy),
    .done           (done),
    .success        (success)
  );

  i2c_sr_err_bank #(.NBITS(ERR_BITS)) u_errs (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (err_clr),
    .set_vec(err_set),
    .flags  (err_flags)
  );

  AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && !busy) |=> busy); // R2
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!addr_issue && !stop_issue && !done && !clr_bus_err)); // R1
endmodule

// File: tb/i2c_start_retry_test.sv
`timescale 1ns/1ps
module i2c_start_retry_test;
  localparam int CPM = 16;
  localparam int TMO = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_req = 0, rd_dir = 0, err_clr = 0, bus_busy = 0, bus_err_pending = 0;
  logic       addr_done = 0, addr_ack = 0, arb_lost = 0, bus_fault = 0;
  logic [6:0] dev_addr = '0;
  logic       clr_bus_err, force_idle, addr_issue, stop_issue, xfer_cnt_clr, busy, done, success;
  logic [7:0] addr_byte;
  logic [3:0] err_flags;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  logic [3:0] model = '0;

  i2c_start_retry #(.CYCLES_PER_MS(CPM), .TIMEOUT_MS(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .rd_dir(rd_dir), .dev_addr(dev_addr),
    .err_clr(err_clr), .bus_busy(bus_busy), .bus_err_pending(bus_err_pending),
    .addr_done(addr_done), .addr_ack(addr_ack), .arb_lost(arb_lost), .bus_fault(bus_fault),
    .clr_bus_err(clr_bus_err), .force_idle(force_idle), .addr_issue(addr_issue),
    .addr_byte(addr_byte), .stop_issue(stop_issue), .xfer_cnt_clr(xfer_cnt_clr),
    .busy(busy), .done(done), .success(success), .err_flags(err_flags)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input logic [6:0] a, input logic rd);
    return (8'(a) * 8'd2) + 8'(rd);
  endfunction

  // response codes: 0 arbitration lost, 1 bus fault, 2 ack, 3 nack, 4 both faults
  task automatic txn(input bit rd, input int forced, input bit nack_all, input int tgt, input bit clr_end);
    logic [6:0] a = 7'($urandom);
    logic pend = 1'($urandom);
    int s, attempts = 0;
    bit finished = 0;
    @(negedge clk);
    dev_addr = a; rd_dir = rd; bus_err_pending = pend; start_req = 1;
    @(negedge clk);
    s = cyc;
    start_req = 0; dev_addr = ~a; rd_dir = ~rd; bus_busy = 1;
    #1;
    chk("R2", "busy after accept", busy, 1);
    chk("R3", "clr_bus_err in prep", clr_bus_err, pend);
    chk("R3", "force_idle in prep", force_idle, pend);
    while (!finished) begin
      int b = 1 + int'($urandom % 4);
      bit spur = ($urandom % 4) == 0;
      int d, code, t;
      bit found = 0, stop_e, xclr_e, retry_e, ok_e, clr_now;
      logic [3:0] setv;
      for (int i = 0; i < b; i++) begin
        @(negedge clk);
        addr_done = (i == 0) && spur; arb_lost = (i == 0) && spur;
        #1;
        chk("R4", "no issue while bus busy", addr_issue, 0);
        if (spur && i == 0) chk("R13", "stray response no stop", stop_issue, 0);
        chk("R3", "prep strobe gone", clr_bus_err, 0);
      end
      @(negedge clk);
      bus_busy = 0; addr_done = 0; arb_lost = 0;
      for (int j = 0; j < 4; j++) begin
        @(negedge clk);
        #1;
        if (addr_issue) begin found = 1; break; end
      end
      chk("R4", "address issued after bus free", found, 1);
      chk("R5", "address byte", addr_byte, exp_byte(a, rd));
      if (attempts == 0 && tgt >= 0) d = s + 1 + tgt - cyc;
      else d = 1 + int'($urandom % 12);
      if (d < 1) d = 1;
      repeat (d) @(negedge clk);
      if (forced >= 0) code = forced;
      else if (nack_all) code = 3;
      else begin
        int p = int'($urandom % 8);
        code = (p < 2) ? p : (p < 5) ? 2 : 3;
      end
      t = cyc - s - 1;
      setv = '0; stop_e = 0; xclr_e = 0; retry_e = 0; ok_e = 0;
      if (code == 0 || code == 1 || code == 4) begin
        setv[0] = (code != 1); setv[1] = (code != 0); stop_e = 1; xclr_e = 1;
      end else if (code == 2) ok_e = 1;
      else if (rd) begin setv[3] = 1; stop_e = 1; end
      else if ((t / CPM) > TMO) begin setv[2] = 1; stop_e = 1; end
      else retry_e = 1;
      clr_now = clr_end && !retry_e;
      addr_done = 1; addr_ack = (code == 2);
      arb_lost = (code == 0 || code == 4); bus_fault = (code == 1 || code == 4);
      err_clr = clr_now;
      #1;
      chk(retry_e ? "R7" : (setv[2] ? "R8" : (setv[3] ? "R9" : (ok_e ? "R10" : "R6"))),
          "stop_issue on response", stop_issue, stop_e);
      chk("R6", "xfer_cnt_clr on response", xfer_cnt_clr, xclr_e);
      @(negedge clk);
      addr_done = 0; addr_ack = 0; arb_lost = 0; bus_fault = 0; err_clr = 0;
      bus_busy = retry_e;
      model = (clr_now ? 4'b0 : model) | setv;
      attempts++;
      #1;
      if (retry_e) begin
        chk("R7", "no done on retry", done, 0);
        if (attempts > 40) begin
          chk("R8", "retry loop bounded", 0, 1);
          finished = 1;
        end
      end else begin
        chk("R11", "done pulse", done, 1);
        chk("R10", "success flag", success, ok_e);
        chk("R12", "sticky err_flags", err_flags, model);
        chk("R11", "busy with done", busy, 1);
        start_req = 1; dev_addr = 7'($urandom);
        @(negedge clk);
        start_req = 0;
        #1;
        chk("R2", "request during done ignored", busy, 0);
        chk("R11", "done single cycle", done, 0);
        finished = 1;
      end
    end
  endtask

  initial begin
    void'($urandom(32'h1C5E_ED01));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #1;
    chk("R1", "busy after reset", busy, 0);
    chk("R1", "done after reset", done, 0);
    chk("R1", "err_flags after reset", err_flags, 0);
    chk("R1", "addr_issue after reset", addr_issue, 0);
    chk("R1", "stop_issue after reset", stop_issue, 0);
    // R7 boundary: first NACK in the last cycle of the allowed window retries
    txn(0, -1, 1, (TMO + 1) * CPM - 1, 0);
    // R8 boundary: first NACK one cycle past the window times out
    txn(0, -1, 1, (TMO + 1) * CPM, 0);
    txn(1, 3, 0, -1, 0);   // R9
    txn(1, 2, 0, -1, 0);   // R10
    txn(0, 0, 0, -1, 0);   // R6 arbitration
    txn(0, 1, 0, -1, 0);   // R6 bus fault
    txn(1, 4, 0, -1, 0);   // R6 both
    @(negedge clk);
    err_clr = 1;
    @(negedge clk);
    err_clr = 0; model = '0;
    #1;
    chk("R12", "clear zeroes flags", err_flags, 0);
    txn(0, 2, 0, -1, 1);   // R12 clear with nothing set
    txn(0, 0, 0, -1, 0);
    txn(1, 3, 0, -1, 1);   // R12 set beats clear
    for (int k = 0; k < 40; k++) begin
      bit rd = 1'($urandom);
      txn(rd, -1, !rd && (($urandom % 4) == 0), -1, ($urandom % 6) == 0);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule